// File: doc/BRIEF.md
# Clock Status Register with Write-Unlock Gate

This block is the volatile status byte of a real-time clock. It reports whether the chip is running from its backup supply, holds one sticky flag per alarm, and keeps two latches that together decide whether the clock and control register space may be written. A clock-fail bit reports that the time has not been set since power-up.

Host byte writes arrive as an address and a data byte with a one-cycle strobe. A write to the status address is interpreted as a command. Writing 02h arms the first latch, then writing 06h arms the second. Writing 00h locks both. Any write to another address is a control-register write, and the gate permits it only while both latches are armed. The serial engine marks the start of a status read and the falling edge of its last data bit. The alarm flags that were already set when the read started are cleared at that last bit. Flags that fire during the read are kept.

Top module: `rtc_status_reg`

## Requirements
- R1: `status_q` has the layout bit 7 backup, bit 6 alarm 1, bit 5 alarm 0, bits 4 and 3 zero, bit 2 second latch, bit 1 first latch, bit 0 clock-fail. After reset it reads 01h, and `ccr_wr_ok` is 0.
- R2: Bit 7 takes the value of `on_backup` one clock later. Status writes never change it.
- R3: A pulse on `alarm_hit[i]` sets the alarm flag for alarm i on the next clock. The flag then stays set until a status read clears it.
- R4: A pulse on `rd_last` clears only the flags that were set in the cycle `rd_start` was pulsed. A flag set after that point stays set. A flag hit in the same cycle as `rd_last` also stays set.
- R5: Writing 02h to the status address sets bit 1 and clears bit 2.
- R6: Writing 06h to the status address sets bit 2 only if bit 1 is already 1. Otherwise the write leaves the register unchanged.
- R7: Writing 00h to the status address clears bits 2 and 1. Any other data value written to the status address changes no bit.
- R8: `ccr_wr_ok` is 1 exactly while bits 2 and 1 are both 1.
- R9: Writes to addresses other than `SR_ADDR` (default 03Fh) leave both latches unchanged. Bit 0 resets to 1 and clears on the first such write made while `ccr_wr_ok` is 1. Such a write made while `ccr_wr_ok` is 0 leaves bit 0 set.
- R10: A `rd_last` pulse with no `rd_start` before it clears no alarm flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle byte-write strobe |
| wr_addr | input | ADDR_W | Byte-write address |
| wr_data | input | 8 | Byte-write data |
| rd_start | input | 1 | Status read has started |
| rd_last | input | 1 | Falling edge of the last data bit of a status read |
| alarm_hit | input | NUM_ALARMS | Per-alarm match pulses |
| on_backup | input | 1 | Chip is running from the backup supply |
| status_q | output | 8 | Status register value |
| ccr_wr_ok | output | 1 | Control-register writes are permitted |

## Verification
The unlock path is driven with the correct 02h then 06h order, with 06h alone, with 06h after a lock, and with unrelated data values. These cases separate a sequence check from a plain bit store. The read path is tested four ways: with a flag set before the read, a flag set during it, a hit that coincides with the last bit, and a last-bit strobe with no start. These cases separate the start-time snapshot from a clear-everything read. Control-register writes are sent both locked and unlocked, so the gate decision shows up on the clock-fail bit.

// File: rtl/rtc_status_pkg.sv
package rtc_status_pkg;
  localparam int SR_W      = 8;
  localparam int BIT_BAT   = 7;
  localparam int BIT_AL1   = 6;
  localparam int BIT_AL0   = 5;
  localparam int BIT_RWEL  = 2;
  localparam int BIT_WEL   = 1;
  localparam int BIT_RTCF  = 0;

  localparam logic [SR_W-1:0] CMD_ARM1 = 8'h02;
  localparam logic [SR_W-1:0] CMD_ARM2 = 8'h06;
  localparam logic [SR_W-1:0] CMD_LOCK = 8'h00;
endpackage

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic rd_start,
  input  logic rd_last,
  output logic flag_q
);
  logic snap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      snap_q <= 1'b0;
    end else if (rd_last) begin
      flag_q <= (flag_q & ~snap_q) | hit;
      snap_q <= 1'b0;
    end else begin
      flag_q <= flag_q | hit;
      if (rd_start) snap_q <= flag_q;
    end
  end
endmodule

// File: rtl/rtc_wr_gate.sv
module rtc_wr_gate
  import rtc_status_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            sr_wr,
  input  logic            ccr_wr,
  input  logic [SR_W-1:0] wr_data,
  output logic            wel_q,
  output logic            rwel_q,
  output logic            rtcf_q,
  output logic            open_o
);
  assign open_o = wel_q & rwel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q  <= 1'b0;
      rwel_q <= 1'b0;
      rtcf_q <= 1'b1;
    end else begin
      if (sr_wr) begin
        case (wr_data)
          CMD_ARM1: begin
            wel_q  <= 1'b1;
            rwel_q <= 1'b0;
          end
          CMD_ARM2: if (wel_q) rwel_q <= 1'b1;
          CMD_LOCK: begin
            wel_q  <= 1'b0;
            rwel_q <= 1'b0;
          end
          default: ;
        endcase
      end
      if (ccr_wr && open_o) rtcf_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_status_reg.sv
module rtc_status_reg
  import rtc_status_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int SR_ADDR    = 'h03F,
  parameter int NUM_ALARMS = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [SR_W-1:0]       wr_data,
  input  logic                  rd_start,
  input  logic                  rd_last,
  input  logic [NUM_ALARMS-1:0] alarm_hit,
  input  logic                  on_backup,
  output logic [SR_W-1:0]       status_q,
  output logic                  ccr_wr_ok
);
  localparam logic [ADDR_W-1:0] SR_A = ADDR_W'(SR_ADDR);
  localparam int FLAG_SLOTS = 2;

  logic                  is_sr;
  logic                  sr_wr;
  logic                  ccr_wr;
  logic                  bat_q;
  logic                  wel_q;
  logic                  rwel_q;
  logic                  rtcf_q;
  logic [NUM_ALARMS-1:0] flags;
  logic [FLAG_SLOTS-1:0] flag_view;

  assign is_sr  = (wr_addr == SR_A);
  assign sr_wr  = wr_en & is_sr;
  assign ccr_wr = wr_en & ~is_sr;

  always_ff @(posedge clk) begin
    if (rst) bat_q <= 1'b0;
    else     bat_q <= on_backup;
  end

  for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_alarm
    rtc_alarm_flag u_flag (
      .clk      (clk),
      .rst      (rst),
      .hit      (alarm_hit[i]),
      .rd_start (rd_start),
      .rd_last  (rd_last),
      .flag_q   (flags[i])
    );
  end

  for (genvar j = 0; j < FLAG_SLOTS; j++) begin : g_view
    if (j < NUM_ALARMS) begin : g_used
      assign flag_view[j] = flags[j];
    end else begin : g_empty
      assign flag_view[j] = 1'b0;
    end
  end

  rtc_wr_gate u_gate (
    .clk     (clk),
    .rst     (rst),
    .sr_wr   (sr_wr),
    .ccr_wr  (ccr_wr),
    .wr_data (wr_data),
    .wel_q   (wel_q),
    .rwel_q  (rwel_q),
    .rtcf_q  (rtcf_q),
    .open_o  (ccr_wr_ok)
  );

  always_comb begin
    status_q           = '0;
    status_q[BIT_BAT]  = bat_q;
    status_q[BIT_AL1]  = flag_view[1];
    status_q[BIT_AL0]  = flag_view[0];
    status_q[BIT_RWEL] = rwel_q;
    status_q[BIT_WEL]  = wel_q;
    status_q[BIT_RTCF] = rtcf_q;
  end
endmodule

// File: rtl/rtc_status_chk.sv
module rtc_status_chk
  import rtc_status_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int SR_ADDR    = 'h03F,
  parameter int NUM_ALARMS = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic [SR_W-1:0]       wr_data,
  input logic                  rd_start,
  input logic                  rd_last,
  input logic [NUM_ALARMS-1:0] alarm_hit,
  input logic                  on_backup,
  input logic [SR_W-1:0]       status_q,
  input logic                  ccr_wr_ok
);
  localparam logic [ADDR_W-1:0] SR_A = ADDR_W'(SR_ADDR);

  // R2
  a_r2_bat_follow: assert property (@(posedge clk) disable iff (rst)
    on_backup |=> status_q[BIT_BAT]);

  // R3
  a_r3_alarm_set: assert property (@(posedge clk) disable iff (rst)
    alarm_hit[0] |=> status_q[BIT_AL0]);

  // R4
  a_r4_clear_on_last: assert property (@(posedge clk) disable iff (rst)
    $fell(status_q[BIT_AL0]) |-> $past(rd_last));

  // R6
  a_r6_arm2_source: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q[BIT_RWEL]) |-> $past(wr_en && wr_addr == SR_A &&
                                         wr_data == CMD_ARM2 && status_q[BIT_WEL]));

  // R8
  a_r8_open_needs_both: assert property (@(posedge clk) disable iff (rst)
    ccr_wr_ok |-> (status_q[BIT_RWEL] && status_q[BIT_WEL]));

  // R9
  a_r9_rtcf_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(status_q[BIT_RTCF]) |-> $past(wr_en && wr_addr != SR_A && ccr_wr_ok));
endmodule

bind rtc_status_reg rtc_status_chk #(
  .ADDR_W(ADDR_W), .SR_ADDR(SR_ADDR), .NUM_ALARMS(NUM_ALARMS)
) u_chk (.*);

// File: tb/rtc_status_reg_bench.sv
module rtc_status_reg_bench;
  localparam int ADDR_W = 9;
  localparam logic [ADDR_W-1:0] SR = 9'h03F;
  localparam logic [ADDR_W-1:0] CR = 9'h031;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic              rd_start = 1'b0;
  logic              rd_last = 1'b0;
  logic [1:0]        alarm_hit = '0;
  logic              on_backup = 1'b0;
  logic [7:0]        status_q;
  logic              ccr_wr_ok;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_status_reg u_rtc_status_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_start(rd_start), .rd_last(rd_last), .alarm_hit(alarm_hit),
    .on_backup(on_backup), .status_q(status_q), .ccr_wr_ok(ccr_wr_ok)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic hit(input logic [1:0] h);
    @(negedge clk); alarm_hit = h;
    @(negedge clk); alarm_hit = '0;
  endtask

  task automatic rstart();
    @(negedge clk); rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
  endtask

  task automatic rlast(input logic [1:0] h);
    @(negedge clk); rd_last = 1'b1; alarm_hit = h;
    @(negedge clk); rd_last = 1'b0; alarm_hit = '0;
  endtask

  task automatic t_reset();
    chk("R1 reset value", status_q, 8'h01);
    chk("R1 reset gate", {7'b0, ccr_wr_ok}, 8'h00);
  endtask

  task automatic t_sequence();
    wr(SR, 8'h06);
    chk("R6 arm2 without arm1", status_q, 8'h01);
    wr(SR, 8'h02);
    chk("R5 arm1", status_q, 8'h03);
    chk("R8 gate after arm1", {7'b0, ccr_wr_ok}, 8'h00);
    wr(SR, 8'h06);
    chk("R6 arm2 after arm1", status_q, 8'h07);
    chk("R8 gate open", {7'b0, ccr_wr_ok}, 8'h01);
    wr(SR, 8'h55);
    chk("R7 other value ignored", status_q, 8'h07);
    wr(SR, 8'h02);
    chk("R5 arm1 clears second latch", status_q, 8'h03);
    wr(SR, 8'h00);
    chk("R7 lock", status_q, 8'h01);
    wr(SR, 8'h06);
    chk("R6 arm2 after lock", status_q, 8'h01);
  endtask

  task automatic t_ccr();
    wr(CR, 8'h00);
    chk("R9 locked ccr write keeps fail bit", status_q, 8'h01);
    wr(SR, 8'h02);
    wr(SR, 8'h06);
    wr(CR, 8'h00);
    chk("R9 unlocked ccr write clears fail bit, latches kept", status_q, 8'h06);
    chk("R8 gate still open", {7'b0, ccr_wr_ok}, 8'h01);
    wr(SR, 8'h00);
    chk("R8 gate closed after lock", {7'b0, ccr_wr_ok}, 8'h00);
  endtask

  task automatic t_bat();
    @(negedge clk); on_backup = 1'b1;
    @(negedge clk);
    chk("R2 backup set", status_q, 8'h80);
    wr(SR, 8'hFF);
    wr(SR, 8'h00);
    chk("R2 writes keep backup bit", status_q, 8'h80);
    @(negedge clk); on_backup = 1'b0;
    @(negedge clk);
    chk("R2 backup clear", status_q, 8'h00);
  endtask

  task automatic t_alarms();
    hit(2'b01);
    chk("R3 alarm0 set", status_q, 8'h20);
    repeat (3) @(negedge clk);
    chk("R3 alarm0 sticky", status_q, 8'h20);
    rlast(2'b00);
    chk("R10 last without start", status_q, 8'h20);
    rstart();
    hit(2'b10);
    chk("R3 alarm1 set during read", status_q, 8'h60);
    rlast(2'b00);
    chk("R4 only captured flag cleared", status_q, 8'h40);
    rstart();
    rlast(2'b10);
    chk("R4 hit on last bit survives", status_q, 8'h40);
    rstart();
    rlast(2'b00);
    chk("R4 second read clears alarm1", status_q, 8'h00);
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sequence();
    t_ccr();
    t_bat();
    t_alarms();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule